// File: doc/BRIEF.md
# Card Bus Power State Controller

This block sets the electrical state of the card-side pins of an SD/MMC host. A 2-bit power field, loaded through a one-cycle register write port, picks one of three states. In the off state every card line (clock, command and all eight data lanes) is driven high. In the cycle state every line is driven low, so a card whose supply has been removed cannot draw current through its signal pins. In the on state the pads carry the values and output enables of the functional host logic.

Software powers a card down by writing the cycle state and powers it up by writing off and then on. A direct jump from cycle to on is refused: the write is dropped and a sticky sequence-error flag is raised, which only reset clears. A separate polarity bit in the same write word inverts the direction signal sent to an external level-shifting transceiver. The reserved field value is taken as off.

Top module: `card_pwr_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, the state reads 00 (off), the polarity bit is 0, the sequence-error flag is 0, and every pad is driven high with its enable set.
- R2: In the off state (00) the clock, command and all eight data pads output 1 with their output enables at 1.
- R3: In the cycle state (10) the clock, command and all eight data pads output 0 with their output enables at 1.
- R4: In the on state (11) each pad output and output enable equals the matching functional input.
- R5: A write whose power field (write data bits 1:0) holds the reserved value 01 puts the block in the off state 00.
- R6: A write of field 11 while in the cycle state is ignored as a whole (state and polarity keep their values) and sets the sequence-error flag.
- R7: The sequence-error flag stays set until reset; the legal path cycle, then off, then on is accepted without raising it.
- R8: The direction output equals A XOR P, where P is the polarity bit (write data bit 4) and A is 1 outside the on state and the functional direction input in the on state.
- R9: With the write strobe low, state and polarity do not change whatever the write data holds; an accepted write takes effect on the pads one clock after the strobe edge.
- R10: The state output always reports one of 00, 10 or 11, never the reserved value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the power word |
| wr_data | input | 8 | Power word: bits 1:0 power field, bit 4 direction polarity |
| fn_clk_o | input | 1 | Functional card clock value |
| fn_clk_oe | input | 1 | Functional card clock enable |
| fn_cmd_o | input | 1 | Functional command line value |
| fn_cmd_oe | input | 1 | Functional command line enable |
| fn_dat_o | input | 8 | Functional data lane values |
| fn_dat_oe | input | 8 | Functional data lane enables |
| fn_dir | input | 1 | Functional transceiver direction (1 = host drives) |
| pad_clk_o | output | 1 | Clock pad value |
| pad_clk_oe | output | 1 | Clock pad enable |
| pad_cmd_o | output | 1 | Command pad value |
| pad_cmd_oe | output | 1 | Command pad enable |
| pad_dat_o | output | 8 | Data pad values |
| pad_dat_oe | output | 8 | Data pad enables |
| pad_dir_o | output | 1 | Transceiver direction after polarity |
| pwr_state_o | output | 2 | Current power state encoding |
| seq_err_o | output | 1 | Sticky sequence-error flag |

## Verification
The only register stage is the power state, polarity and error flag, so a write presented before a rising edge shows on the state, error and pad outputs right after that edge, while a change on the functional inputs passes to the pads in the same cycle. The bench drives inputs on the falling edge, lets the rising edge take the write, updates its own model at that edge and compares all outputs one nanosecond later, before the next input change. Random writes with a fixed seed are mixed with directed sequences for the reserved value, the refused cycle-to-on jump, the legal recovery path and a strobe-low write.

// File: rtl/card_pwr_pkg.sv
package card_pwr_pkg;

    typedef enum logic [1:0] {
        PWR_OFF   = 2'b00,
        PWR_RSVD  = 2'b01,
        PWR_CYCLE = 2'b10,
        PWR_ON    = 2'b11
    } pwr_mode_e;

    typedef struct packed {
        logic o;
        logic oe;
    } lane_t;

    // Reserved code folds onto off; other codes map directly.
    function automatic pwr_mode_e resolve_field(input logic [1:0] f);
        pwr_mode_e m;
        case (f)
            2'b10:   m = PWR_CYCLE;
            2'b11:   m = PWR_ON;
            default: m = PWR_OFF;
        endcase
        return m;
    endfunction

    function automatic logic seq_violation(input pwr_mode_e cur, input pwr_mode_e req);
        return (cur == PWR_CYCLE) && (req == PWR_ON);
    endfunction

    // Value a lane holds while it is not under functional control.
    function automatic lane_t park_lane(input pwr_mode_e m);
        lane_t l;
        l.o  = (m != PWR_CYCLE);
        l.oe = 1'b1;
        return l;
    endfunction

endpackage

// File: rtl/card_pwr_regs.sv
module card_pwr_regs
    import card_pwr_pkg::*;
#(
    parameter int WR_W      = 8,
    parameter int FIELD_LSB = 0,
    parameter int POL_BIT   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    output pwr_mode_e       mode,
    output logic            dir_pol,
    output logic            seq_err
);

    logic [1:0] field;
    pwr_mode_e  req_mode;
    logic       refuse;

    always_comb begin
        field    = wr_data[FIELD_LSB +: 2];
        req_mode = resolve_field(field);
        refuse   = seq_violation(mode, req_mode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= PWR_OFF;
            dir_pol <= 1'b0;
            seq_err <= 1'b0;
        end else if (wr_en) begin
            if (refuse) begin
                seq_err <= 1'b1;
            end else begin
                mode    <= req_mode;
                dir_pol <= wr_data[POL_BIT];
            end
        end
    end

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (mode == PWR_OFF && !dir_pol && !seq_err));

    assert_rsvd_off_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[FIELD_LSB +: 2] == 2'b01) |=> (mode == PWR_OFF));

    assert_seq_block_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mode == PWR_CYCLE && wr_data[FIELD_LSB +: 2] == 2'b11)
        |=> (mode == PWR_CYCLE && seq_err && $stable(dir_pol)));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> seq_err);

    assert_no_direct_on_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == PWR_CYCLE) |=> (mode != PWR_ON));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(mode) && $stable(dir_pol)));

    assert_legal_R10: assert property (@(posedge clk) disable iff (rst)
        mode != PWR_RSVD);

endmodule

// File: rtl/card_pwr_lane_mux.sv
module card_pwr_lane_mux
    import card_pwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pwr_mode_e mode,
    input  lane_t     fn_lane,
    output lane_t     pad_lane
);

    always_comb begin
        if (mode == PWR_ON) pad_lane = fn_lane;
        else                pad_lane = park_lane(mode);
    end

    assert_off_high_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == PWR_OFF) |-> (pad_lane.o && pad_lane.oe));

    assert_cycle_low_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == PWR_CYCLE) |-> (!pad_lane.o && pad_lane.oe));

    assert_on_follow_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == PWR_ON) |-> (pad_lane == fn_lane));

endmodule

// File: rtl/card_pwr_dir.sv
module card_pwr_dir
    import card_pwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pwr_mode_e mode,
    input  logic      dir_pol,
    input  logic      fn_dir,
    output logic      pad_dir
);

    logic active;

    always_comb begin
        active  = (mode == PWR_ON) ? fn_dir : 1'b1;
        pad_dir = active ^ dir_pol;
    end

    assert_dir_park_R8: assert property (@(posedge clk) disable iff (rst)
        (mode != PWR_ON) |-> (pad_dir == !dir_pol));

endmodule

// File: rtl/card_pwr_ctrl.sv
module card_pwr_ctrl
    import card_pwr_pkg::*;
#(
    parameter int LANES     = 8,
    parameter int WR_W      = 8,
    parameter int FIELD_LSB = 0,
    parameter int POL_BIT   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WR_W-1:0]  wr_data,
    input  logic             fn_clk_o,
    input  logic             fn_clk_oe,
    input  logic             fn_cmd_o,
    input  logic             fn_cmd_oe,
    input  logic [LANES-1:0] fn_dat_o,
    input  logic [LANES-1:0] fn_dat_oe,
    input  logic             fn_dir,
    output logic             pad_clk_o,
    output logic             pad_clk_oe,
    output logic             pad_cmd_o,
    output logic             pad_cmd_oe,
    output logic [LANES-1:0] pad_dat_o,
    output logic [LANES-1:0] pad_dat_oe,
    output logic             pad_dir_o,
    output logic [1:0]       pwr_state_o,
    output logic             seq_err_o
);

    localparam int N_LINES = LANES + 2;
    localparam int CLK_IDX = LANES;
    localparam int CMD_IDX = LANES + 1;

    pwr_mode_e mode;
    logic      dir_pol;
    lane_t     fn_bus  [N_LINES];
    lane_t     pad_bus [N_LINES];

    card_pwr_regs #(
        .WR_W      (WR_W),
        .FIELD_LSB (FIELD_LSB),
        .POL_BIT   (POL_BIT)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .mode    (mode),
        .dir_pol (dir_pol),
        .seq_err (seq_err_o)
    );

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            fn_bus[i].o  = fn_dat_o[i];
            fn_bus[i].oe = fn_dat_oe[i];
        end
        fn_bus[CLK_IDX].o  = fn_clk_o;
        fn_bus[CLK_IDX].oe = fn_clk_oe;
        fn_bus[CMD_IDX].o  = fn_cmd_o;
        fn_bus[CMD_IDX].oe = fn_cmd_oe;
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        card_pwr_lane_mux u_mux (
            .clk      (clk),
            .rst      (rst),
            .mode     (mode),
            .fn_lane  (fn_bus[g]),
            .pad_lane (pad_bus[g])
        );
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            pad_dat_o[i]  = pad_bus[i].o;
            pad_dat_oe[i] = pad_bus[i].oe;
        end
        pad_clk_o  = pad_bus[CLK_IDX].o;
        pad_clk_oe = pad_bus[CLK_IDX].oe;
        pad_cmd_o  = pad_bus[CMD_IDX].o;
        pad_cmd_oe = pad_bus[CMD_IDX].oe;
        pwr_state_o = mode;
    end

    card_pwr_dir u_dir (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .dir_pol (dir_pol),
        .fn_dir  (fn_dir),
        .pad_dir (pad_dir_o)
    );

endmodule

// File: tb/card_pwr_ctrl_test.sv
`timescale 1ns/1ps
module card_pwr_ctrl_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       fn_clk_o, fn_clk_oe, fn_cmd_o, fn_cmd_oe, fn_dir;
    logic [7:0] fn_dat_o, fn_dat_oe;
    logic       pad_clk_o, pad_clk_oe, pad_cmd_o, pad_cmd_oe, pad_dir_o, seq_err_o;
    logic [7:0] pad_dat_o, pad_dat_oe;
    logic [1:0] pwr_state_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [1:0] m_state;
    logic       m_pol;
    logic       m_err;

    always #2.5 clk = ~clk;

    card_pwr_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .fn_clk_o(fn_clk_o), .fn_clk_oe(fn_clk_oe),
        .fn_cmd_o(fn_cmd_o), .fn_cmd_oe(fn_cmd_oe),
        .fn_dat_o(fn_dat_o), .fn_dat_oe(fn_dat_oe), .fn_dir(fn_dir),
        .pad_clk_o(pad_clk_o), .pad_clk_oe(pad_clk_oe),
        .pad_cmd_o(pad_cmd_o), .pad_cmd_oe(pad_cmd_oe),
        .pad_dat_o(pad_dat_o), .pad_dat_oe(pad_dat_oe),
        .pad_dir_o(pad_dir_o), .pwr_state_o(pwr_state_o), .seq_err_o(seq_err_o)
    );

    function automatic logic [19:0] fn_vec();
        return {fn_clk_o, fn_clk_oe, fn_cmd_o, fn_cmd_oe, fn_dat_o, fn_dat_oe};
    endfunction

    function automatic logic [19:0] pad_vec();
        return {pad_clk_o, pad_clk_oe, pad_cmd_o, pad_cmd_oe, pad_dat_o, pad_dat_oe};
    endfunction

    function automatic logic [19:0] exp_pads(input logic [1:0] st, input logic [19:0] fn);
        if (st == 2'b11) return fn;
        if (st == 2'b10) return {1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'hFF};
        return {1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF};
    endfunction

    function automatic logic exp_dir(input logic [1:0] st, input logic pol, input logic d);
        return ((st == 2'b11) ? d : 1'b1) ^ pol;
    endfunction

    function automatic string pad_req(input logic [1:0] st);
        if (st == 2'b11) return "R4";
        if (st == 2'b10) return "R3";
        return "R2";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic [1:0] f;
        if (rst) begin
            m_state = 2'b00; m_pol = 1'b0; m_err = 1'b0;
        end else if (wr_en) begin
            f = wr_data[1:0];
            if (m_state == 2'b10 && f == 2'b11) begin
                m_err = 1'b1;
            end else begin
                m_state = (f == 2'b01) ? 2'b00 : f;
                m_pol   = wr_data[4];
            end
        end
    endtask

    task automatic check_all(input string tag);
        check({pad_req(m_state), " pads ", tag}, {12'd0, pad_vec()}, {12'd0, exp_pads(m_state, fn_vec())});
        check({"R8 dir ", tag}, {31'd0, pad_dir_o}, {31'd0, exp_dir(m_state, m_pol, fn_dir)});
        check({"R10 state ", tag}, {30'd0, pwr_state_o}, {30'd0, m_state});
        check({"R7 err ", tag}, {31'd0, seq_err_o}, {31'd0, m_err});
    endtask

    task automatic rand_fn();
        {fn_clk_o, fn_clk_oe, fn_cmd_o, fn_cmd_oe, fn_dir} = 5'($urandom);
        fn_dat_o  = 8'($urandom);
        fn_dat_oe = 8'($urandom);
    endtask

    task automatic step(input logic we, input logic [7:0] d, input string tag);
        @(negedge clk);
        wr_en = we; wr_data = d;
        rand_fn();
        @(posedge clk);
        model_edge();
        #1;
        check_all(tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; wr_en = 1'b0; wr_data = 8'h00;
        fn_clk_o = 0; fn_clk_oe = 0; fn_cmd_o = 0; fn_cmd_oe = 0; fn_dir = 0;
        fn_dat_o = 0; fn_dat_oe = 0;
        m_state = 2'b00; m_pol = 1'b0; m_err = 1'b0;

        // R1: reset state, with a write attempt held off by reset
        step(1'b1, 8'h13, "R1 reset");
        step(1'b0, 8'h00, "R1 reset");
        check("R1 pads", {12'd0, pad_vec()}, {12'd0, 20'hF_FFFF});
        @(negedge clk); rst = 1'b0;

        // R9: strobe low leaves state untouched, then one-cycle latency
        step(1'b0, 8'h13, "R9 no strobe");
        check("R9 state held", {30'd0, pwr_state_o}, 32'd0);
        step(1'b1, 8'h03, "R9 on");
        check("R9 on after one edge", {30'd0, pwr_state_o}, 32'd3);

        // R5: reserved field value goes to off
        step(1'b1, 8'h01, "R5 rsvd");
        check("R5 rsvd is off", {30'd0, pwr_state_o}, 32'd0);

        // R6: cycle then direct on is refused, polarity kept
        step(1'b1, 8'h02, "R3 cycle");
        step(1'b1, 8'h13, "R6 refuse");
        check("R6 stays cycle", {30'd0, pwr_state_o}, 32'd2);
        check("R6 err set", {31'd0, seq_err_o}, 32'd1);
        check("R6 pol kept", {31'd0, pad_dir_o}, 32'd1);

        // R7: legal recovery and stickiness
        step(1'b1, 8'h10, "R7 off");
        step(1'b1, 8'h13, "R7 on");
        check("R7 on reached", {30'd0, pwr_state_o}, 32'd3);
        check("R7 err sticky", {31'd0, seq_err_o}, 32'd1);

        // clear flag, then legal path without error
        @(negedge clk); rst = 1'b1;
        @(posedge clk); model_edge();
        @(negedge clk); rst = 1'b0;
        step(1'b1, 8'h02, "R7 cycle");
        step(1'b1, 8'h00, "R7 off");
        step(1'b1, 8'h03, "R7 on");
        check("R7 no err on legal path", {31'd0, seq_err_o}, 32'd0);

        // random mix
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 3) != 0, 8'($urandom), "rand");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule